// File: doc/BRIEF.md
# Reference Divider and Phase-Frequency Detector

This block sits in the digital part of an integer-N frequency synthesizer. A reference square wave `ref_in` is divided by a programmable integer to form the comparison signal `fc_out`. A phase-frequency detector compares the rising edges of `fc_out` with the rising edges of the divided oscillator feedback `fp_in`. It drives two active-low pump outputs. `pd_up_n` asks for a higher oscillator frequency and `pd_dn_n` asks for a lower one. Each low pulse lasts as many clocks as the gap between the two edges.

All inputs are plain level signals sampled on the rising edge of `clk`. No stream handshake is involved: every output is a level that is updated every clock. A raw lock indication `nand_raw` is high whenever either pump output is active. A digital lock flag `lock` replaces an external RC filter. It is set only after a run of comparison cycles in which no pump pulse reaches a programmable length, and it is cleared as soon as one does. Power-down parks the divider and the detector while leaving the edge history running.

Top module: `pfd_refdiv_top`

## Requirements
- R1: For `r_div` = N with N from 1 to 63, `fc_out` rises once for every N+1 rising edges of `ref_in`, as a one-clock high pulse. After reset or power-down, the first pulse appears one clock after the (N+1)-th reference rising edge is sampled. A count already above a newly written N wraps on the next reference edge.
- R2: For `r_div` = 0, `fc_out` follows the level of `ref_in` with a delay of one clock.
- R3: Only rising edges matter. `ref_in` and `fp_in` held high, or held low, produce no further pump activity once both edges of a comparison have been seen.
- R4: Take a reference rising edge sampled on clock k (with `r_div` = 0) and an `fp_in` rising edge sampled on clock k+d, where d > 0. Then `pd_up_n` is low for exactly d clocks and `pd_dn_n` stays high. Both inputs reach the detector with the same two-clock latency.
- R5: With the order reversed, so that `fp_in` leads by d clocks, `pd_dn_n` is low for exactly d clocks and `pd_up_n` stays high.
- R6: Edges sampled on the same clock produce no pulse. `pd_up_n` and `pd_dn_n` are never low together. An active pump returns high on the clock that registers the second edge.
- R7: `nand_raw` is 1 exactly when `pd_up_n` or `pd_dn_n` is 0.
- R8: `lock` goes to 1 on the 16th consecutive `fc_out` comparison edge counted with no long pump run. A long run is a run of consecutive `nand_raw`-high clocks that reaches `lock_thresh` clocks (a threshold of 0 makes any active clock long). When a run reaches `lock_thresh` clocks, `lock` goes to 0 on the next clock and the count restarts.
- R9: While `pwr_dn` is 1, both pump outputs are high, `lock` is 0, `fc_out` is 0, and the divider count is cleared. After release, the next `fc_out` pulse needs a full N+1 reference edges.
- R10: After reset, `fc_out` = 0, `pd_up_n` = 1, `pd_dn_n` = 1, `nand_raw` = 0 and `lock` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference square wave |
| fp_in | input | 1 | Divided oscillator feedback |
| r_div | input | 6 | Reference divide value N (divide by N+1) |
| lock_thresh | input | 8 | Pump run length, in clocks, that counts as long |
| pwr_dn | input | 1 | Power-down: parks divider, pumps and lock |
| fc_out | output | 1 | Divided comparison signal |
| pd_up_n | output | 1 | Active-low pump-up output |
| pd_dn_n | output | 1 | Active-low pump-down output |
| nand_raw | output | 1 | High while either pump is active |
| lock | output | 1 | Filtered lock flag |

## Verification
The hardest states to reach are a pump run that is exactly one clock shorter than `lock_thresh`, or exactly equal to it, while `lock` is already set. Reaching them needs sixteen steady comparison cycles first, followed by a controlled change of phase. Directed stimulus produces these states with two periodic streams at a fixed offset, stepped from threshold minus one to the threshold. A divider count left over across a power-down is made observable by stopping the reference partway through a division. Fixed-seed random segments then vary the divide value, threshold, periods, phase and power-down pulses, and a per-clock bench model is checked against every output.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned REF_W_DEF  = 6;
  localparam int unsigned THR_W_DEF  = 8;
  localparam int unsigned LOCK_N_DEF = 16;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;
endpackage

// File: rtl/pfd_ref_div.sv
module pfd_ref_div #(
  parameter int unsigned R_W       = pfd_pkg::REF_W_DEF,
  parameter bit          ZERO_PASS = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_in,
  input  logic           pwr_dn,
  input  logic [R_W-1:0] r_val,
  output logic           fc
);
  logic           ref_q;
  logic           hit;
  logic           fc_pulse;
  logic [R_W-1:0] cnt;

  assign hit = ref_in & ~ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= 1'b0;
      cnt      <= '0;
      fc_pulse <= 1'b0;
    end else if (pwr_dn) begin
      ref_q    <= 1'b0;
      cnt      <= '0;
      fc_pulse <= 1'b0;
    end else begin
      ref_q <= ref_in;
      if (hit) begin
        if (cnt >= r_val) begin
          cnt      <= '0;
          fc_pulse <= 1'b1;
        end else begin
          cnt      <= cnt + 1'b1;
          fc_pulse <= 1'b0;
        end
      end else begin
        fc_pulse <= 1'b0;
      end
    end
  end

  generate
    if (ZERO_PASS) begin : g_pass
      assign fc = (r_val == '0) ? ref_q : fc_pulse;
    end else begin : g_div_only
      assign fc = fc_pulse;
    end
  endgenerate

  // R1: an output pulse only follows a sampled reference rise
  assert_pulse_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fc_pulse |-> $past(ref_in && !ref_q));
endmodule

// File: rtl/pfd_detector.sv
module pfd_detector
  import pfd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fc_in,
  input  logic  fp_in,
  input  logic  pwr_dn,
  output pump_t pump,
  output logic  fc_edge
);
  logic  fc_d;
  logic  fp_q;
  logic  fp_d;
  logic  fp_edge;
  pump_t nxt;

  assign fc_edge = fc_in & ~fc_d;
  assign fp_edge = fp_q & ~fp_d;

  always_comb begin
    nxt.up = pump.up | fc_edge;
    nxt.dn = pump.dn | fp_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_d <= 1'b0;
      fp_q <= 1'b0;
      fp_d <= 1'b0;
      pump <= '0;
    end else begin
      fc_d <= fc_in;
      fp_q <= fp_in;
      fp_d <= fp_q;
      if (pwr_dn || (nxt.up && nxt.dn)) pump <= '0;
      else                              pump <= nxt;
    end
  end

  assert_up_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump.up) |-> ($past(fc_in) && !$past(pwr_dn)));
  assert_dn_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump.dn) |-> ($past(fp_q && !fp_d) && !$past(pwr_dn)));
  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump.up && pump.dn));
  assert_pwrdn_pump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!pump.up && !pump.dn));
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter
  import pfd_pkg::*;
#(
  parameter int unsigned THR_W  = THR_W_DEF,
  parameter int unsigned LOCK_N = LOCK_N_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  pump_t            pump,
  input  logic             fc_edge,
  input  logic [THR_W-1:0] thr,
  output logic             nand_raw,
  output logic             lock
);
  localparam int unsigned GC_W = $clog2(LOCK_N + 1);

  logic [THR_W-1:0] wc;
  logic [THR_W:0]   wc_inc;
  logic             long_run;
  logic [GC_W-1:0]  good;
  logic [GC_W-1:0]  good_inc;

  assign nand_raw = pump.up | pump.dn;
  assign wc_inc   = {1'b0, wc} + {{THR_W{1'b0}}, 1'b1};
  assign long_run = nand_raw && (wc_inc >= {1'b0, thr});
  assign good_inc = good + GC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc   <= '0;
      good <= '0;
      lock <= 1'b0;
    end else if (pwr_dn) begin
      wc   <= '0;
      good <= '0;
      lock <= 1'b0;
    end else begin
      if (!nand_raw)  wc <= '0;
      else if (!(&wc)) wc <= wc + 1'b1;
      if (long_run) begin
        good <= '0;
        lock <= 1'b0;
      end else if (fc_edge) begin
        if (good_inc >= GC_W'(LOCK_N)) begin
          good <= GC_W'(LOCK_N);
          lock <= 1'b1;
        end else begin
          good <= good_inc;
        end
      end
    end
  end

  assert_lock_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(fc_edge));
  assert_long_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    long_run |=> !lock);
  assert_pwrdn_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !lock);
endmodule

// File: rtl/pfd_refdiv_top.sv
module pfd_refdiv_top
  import pfd_pkg::*;
#(
  parameter int unsigned R_W    = REF_W_DEF,
  parameter int unsigned THR_W  = THR_W_DEF,
  parameter int unsigned LOCK_N = LOCK_N_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fp_in,
  input  logic [R_W-1:0]   r_div,
  input  logic [THR_W-1:0] lock_thresh,
  input  logic             pwr_dn,
  output logic             fc_out,
  output logic             pd_up_n,
  output logic             pd_dn_n,
  output logic             nand_raw,
  output logic             lock
);
  pump_t pump;
  logic  fc_edge;

  pfd_ref_div #(.R_W(R_W), .ZERO_PASS(1'b1)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_in (ref_in),
    .pwr_dn (pwr_dn),
    .r_val  (r_div),
    .fc     (fc_out)
  );

  pfd_detector u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .fc_in   (fc_out),
    .fp_in   (fp_in),
    .pwr_dn  (pwr_dn),
    .pump    (pump),
    .fc_edge (fc_edge)
  );

  pfd_lock_filter #(.THR_W(THR_W), .LOCK_N(LOCK_N)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .pump     (pump),
    .fc_edge  (fc_edge),
    .thr      (lock_thresh),
    .nand_raw (nand_raw),
    .lock     (lock)
  );

  assign pd_up_n = ~pump.up;
  assign pd_dn_n = ~pump.dn;

  // R7: the raw indicator tracks the two pump pins
  assert_nand_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nand_raw == (!pd_up_n || !pd_dn_n));
endmodule

// File: tb/pfd_refdiv_top_bench.sv
`timescale 1ns/1ps
module pfd_refdiv_top_bench;
  localparam int R_W = 6;
  localparam int THR_W = 8;
  localparam int LOCK_N = 16;
  localparam int WC_MAX = (1 << THR_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, fp_in = 1'b0, pwr_dn = 1'b0;
  logic [R_W-1:0]   r_div = '0;
  logic [THR_W-1:0] lock_thresh = 8'd4;
  logic fc_out, pd_up_n, pd_dn_n, nand_raw, lock;

  pfd_refdiv_top u_pfd_refdiv_top (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fp_in(fp_in), .r_div(r_div),
    .lock_thresh(lock_thresh), .pwr_dn(pwr_dn), .fc_out(fc_out),
    .pd_up_n(pd_up_n), .pd_dn_n(pd_dn_n), .nand_raw(nand_raw), .lock(lock)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 1'b0;
  int up_low, dn_low, nand_hi, both_low, fc_rises;
  logic fc_prev = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model, written from the requirements
  logic m_refq, m_pulse, m_fcd, m_fpq, m_fpd, m_up, m_dn, m_lock;
  int   m_cnt, m_wc, m_good;

  function automatic logic m_fc();
    return (r_div == '0) ? m_refq : m_pulse;
  endfunction

  always @(posedge clk) begin : model
    logic hit, fcr, fpr, nu, nd, act, longr;
    if (!rst_n) begin
      m_refq <= 1'b0; m_pulse <= 1'b0; m_fcd <= 1'b0; m_fpq <= 1'b0; m_fpd <= 1'b0;
      m_up <= 1'b0; m_dn <= 1'b0; m_lock <= 1'b0; m_cnt <= 0; m_wc <= 0; m_good <= 0;
    end else begin
      hit   = ref_in && !m_refq;
      fcr   = m_fc() && !m_fcd;
      fpr   = m_fpq && !m_fpd;
      nu    = m_up || fcr;
      nd    = m_dn || fpr;
      act   = m_up || m_dn;
      longr = act && ((m_wc + 1) >= int'(lock_thresh));
      m_fcd <= m_fc();
      m_fpq <= fp_in;
      m_fpd <= m_fpq;
      if (pwr_dn) begin
        m_refq <= 1'b0; m_cnt <= 0; m_pulse <= 1'b0; m_up <= 1'b0; m_dn <= 1'b0;
        m_wc <= 0; m_good <= 0; m_lock <= 1'b0;
      end else begin
        m_refq <= ref_in;
        if (hit) begin
          if (m_cnt >= int'(r_div)) begin m_cnt <= 0; m_pulse <= 1'b1; end
          else begin m_cnt <= m_cnt + 1; m_pulse <= 1'b0; end
        end else m_pulse <= 1'b0;
        if (nu && nd) begin m_up <= 1'b0; m_dn <= 1'b0; end
        else begin m_up <= nu; m_dn <= nd; end
        m_wc <= act ? ((m_wc == WC_MAX) ? WC_MAX : m_wc + 1) : 0;
        if (longr) begin m_good <= 0; m_lock <= 1'b0; end
        else if (fcr) begin
          if (m_good + 1 >= LOCK_N) begin m_good <= LOCK_N; m_lock <= 1'b1; end
          else m_good <= m_good + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      check("R1", "fc_out", 32'(fc_out), 32'(m_fc()));
      check("R4", "pd_up_n", 32'(pd_up_n), 32'(!m_up));
      check("R5", "pd_dn_n", 32'(pd_dn_n), 32'(!m_dn));
      check("R7", "nand_raw", 32'(nand_raw), 32'(m_up || m_dn));
      check("R8", "lock", 32'(lock), 32'(m_lock));
    end
  end

  task automatic clr_counts();
    up_low = 0; dn_low = 0; nand_hi = 0; both_low = 0; fc_rises = 0;
  endtask

  task automatic step(input logic r_i, input logic f_i, input logic pd_i);
    @(negedge clk);
    if (!pd_up_n) up_low++;
    if (!pd_dn_n) dn_low++;
    if (nand_raw) nand_hi++;
    if (!pd_up_n && !pd_dn_n) both_low++;
    if (fc_out && !fc_prev) fc_rises++;
    fc_prev = fc_out;
    #1;
    ref_in = r_i; fp_in = f_i; pwr_dn = pd_i;
  endtask

  task automatic periodic(input int cycles, input int pr, input int pf, input int off);
    for (int c = 0; c < cycles; c++)
      step((c % pr) < pr / 2, ((((c - off) % pf) + pf) % pf) < pf / 2, 1'b0);
  endtask

  task automatic pulse_pair(input int d_ref, input int d_fp, input int hold);
    for (int c = 0; c < hold; c++) step(c >= d_ref, c >= d_fp, 1'b0);
    for (int c = 0; c < 6; c++) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic park(input int n);
    for (int c = 0; c < n; c++) step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10", "fc_out", 32'(fc_out), 32'd0);
    check("R10", "pd_up_n", 32'(pd_up_n), 32'd1);
    check("R10", "pd_dn_n", 32'(pd_dn_n), 32'd1);
    check("R10", "nand_raw", 32'(nand_raw), 32'd0);
    check("R10", "lock", 32'(lock), 32'd0);
    #1 rst_n = 1'b1;
    cmp_en = 1'b1;

    // R2 passthrough with one clock delay
    r_div = '0;
    for (int c = 0; c < 4; c++) step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    @(negedge clk); check("R2", "fc after ref rise", 32'(fc_out), 32'd1);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    @(negedge clk); check("R2", "fc after ref fall", 32'(fc_out), 32'd0);
    park(3);

    // R9 leftover count cleared by power-down, then R1 divide by 4
    r_div = 6'd3;
    periodic(16, 8, 8, 0);
    for (int c = 0; c < 3; c++) step(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check("R9", "pd_up_n parked", 32'(pd_up_n), 32'd1);
    check("R9", "pd_dn_n parked", 32'(pd_dn_n), 32'd1);
    check("R9", "lock parked", 32'(lock), 32'd0);
    check("R9", "fc parked", 32'(fc_out), 32'd0);
    step(1'b0, 1'b0, 1'b0);
    clr_counts();
    periodic(88, 8, 8, 0);
    step(1'b0, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b0);
    check("R1", "fc pulses for 11 ref edges", 32'(fc_rises), 32'd2);

    // R4, R3: reference leads by 5, then both held high
    r_div = '0; park(3); clr_counts();
    pulse_pair(2, 7, 40);
    check("R4", "up low clocks", 32'(up_low), 32'd5);
    check("R4", "dn low clocks", 32'(dn_low), 32'd0);
    check("R7", "nand high clocks", 32'(nand_hi), 32'd5);
    check("R3", "no pulse while held high", 32'(up_low + dn_low), 32'd5);

    // R5: feedback leads by 5
    clr_counts();
    pulse_pair(7, 2, 40);
    check("R5", "dn low clocks", 32'(dn_low), 32'd5);
    check("R5", "up low clocks", 32'(up_low), 32'd0);

    // R6: simultaneous edges
    clr_counts();
    pulse_pair(3, 3, 40);
    check("R6", "pump clocks on tie", 32'(up_low + dn_low), 32'd0);
    check("R6", "both low", 32'(both_low), 32'd0);

    // R8 lock with run one short of threshold, then a run reaching it
    lock_thresh = 8'd4; park(2);
    periodic(250, 10, 10, 3);
    @(negedge clk); check("R8", "locked with width 3", 32'(lock), 32'd1);
    periodic(30, 10, 10, 4);
    @(negedge clk); check("R8", "unlocked at width 4", 32'(lock), 32'd0);
    park(2);
    periodic(250, 10, 10, 2);
    @(negedge clk); check("R8", "relocked", 32'(lock), 32'd1);
    periodic(30, 10, 10, 6);
    @(negedge clk); check("R8", "unlocked by wide lead", 32'(lock), 32'd0);

    // constrained random segments against the model
    for (int s = 0; s < 30; s++) begin
      int pr, pf, off;
      r_div = 6'($urandom_range(0, 3));
      lock_thresh = 8'($urandom_range(1, 10));
      pr = $urandom_range(6, 20);
      pf = pr * (int'(r_div) + 1) + (($urandom_range(0, 3) == 0) ? $urandom_range(0, 2) - 1 : 0);
      off = $urandom_range(0, pf - 1);
      periodic(300, pr, pf, off);
      if ($urandom_range(0, 4) == 0) park($urandom_range(1, 4));
    end
    park(2);
    step(1'b0, 1'b0, 1'b0);
    finish_run();
  end
endmodule